// File: doc/BRIEF.md
# Serial Dot-Product Engine

The engine forms the inner product of two eight-element vectors of signed bytes. It has a single multiplier and a single adder, and it reuses them over eight clock cycles. Both vectors are presented in parallel on two wide input ports. A free-running element counter picks one pair of elements per cycle. The product of each pair is added into a 16-bit accumulator.

No start or clear input exists. On the count of zero, the adder takes a forced zero in place of the accumulator. The first product of every pass therefore begins a fresh sum without an idle cycle. When the last pair has been added, the accumulator holds the finished result and a one-cycle strobe marks it. The next pass has already begun by then. The caller must hold both vectors steady for a whole pass and may change them in the strobe cycle.

Top module: `dotprod_serial`

## Requirements
- R1: In every cycle where `dot_valid_o` is 1, `dot_o` equals the sum over k = 0..7 of signed(a_k) * signed(b_k), taken modulo 2^16. Element k of each vector occupies bits [8k+7:8k] of its port, and the vectors are those held during the preceding eight cycles.
- R2: `dot_valid_o` is a single-cycle pulse that repeats exactly every eight cycles while reset is inactive.
- R3: `dot_valid_o` is 0 while `rst_ni` is low and in the first seven cycles after release. Its first pulse follows the eighth rising clock edge after release.
- R4: A sum that leaves the signed 16-bit range wraps silently. For example, all elements at -128 give 0, and all elements at 127 give 16'hF808.
- R5: Each pass starts a new sum from the pass's first product, so back-to-back passes with different vectors give independent results with no clear cycle between them.
- R6: Asserting `rst_ni` in the middle of a pass abandons that pass. The next pulse then comes eight edges after release and carries the sum of the vectors held after release.
- R7: The element multiplexers select element k on count k, in ascending order. The signed multiply is exact for every 8-bit operand, including -128 * -128 = 16384.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the controller |
| vec_a_i | input | 64 | Vector A, eight signed bytes, element k at bits [8k+7:8k] |
| vec_b_i | input | 64 | Vector B, same layout as vector A |
| dot_o | output | 16 | Accumulator, the signed dot product when `dot_valid_o` is 1 |
| dot_valid_o | output | 1 | One-cycle strobe marking a finished dot product |

## Verification
The checker assumes that both vector ports change only on clock edges where the element count is zero. It checks this assumption as a property of its own. The bench respects it by loading new vectors only at the falling edge of a strobe cycle, or before releasing reset. Stimulus covers the following:
- a full sweep of one scalar over all 256 byte values against a fixed mixed-sign partner;
- extreme-value vectors that force wrap-around;
- a pseudo-random series of passes;
- a reset in the middle of a pass.
Expected sums are computed arithmetically modulo 2^16.

// File: rtl/dotprod_pkg.sv
package dotprod_pkg;
  localparam int unsigned DP_N_ELEM = 8;
  localparam int unsigned DP_IN_W   = 8;
  localparam int unsigned DP_ACC_W  = 16;
endpackage

// File: rtl/dotprod_ctrl.sv
module dotprod_ctrl #(
  parameter int unsigned N_ELEM = dotprod_pkg::DP_N_ELEM,
  localparam int unsigned CW    = (N_ELEM > 1) ? $clog2(N_ELEM) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] sel_o,
  output logic          first_o,
  output logic          done_o
);
  localparam logic [CW-1:0] LAST = CW'(N_ELEM - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      done_q <= (cnt_q == LAST);
    end
  end

  assign sel_o   = cnt_q;
  assign first_o = (cnt_q == '0);
  assign done_o  = done_q;
endmodule

// File: rtl/dotprod_elem_sel.sv
module dotprod_elem_sel #(
  parameter int unsigned N_ELEM = dotprod_pkg::DP_N_ELEM,
  parameter int unsigned IN_W   = dotprod_pkg::DP_IN_W,
  localparam int unsigned CW    = (N_ELEM > 1) ? $clog2(N_ELEM) : 1,
  localparam int unsigned VW    = N_ELEM * IN_W
) (
  input  logic [VW-1:0]   vec_i,
  input  logic [CW-1:0]   sel_i,
  output logic [IN_W-1:0] elem_o
);
  logic [IN_W-1:0] elems [N_ELEM];

  for (genvar k = 0; k < N_ELEM; k++) begin : g_unpack
    assign elems[k] = vec_i[k*IN_W +: IN_W];
  end

  always_comb begin
    elem_o = '0;
    for (int k = 0; k < N_ELEM; k++) begin
      if (sel_i == CW'(k)) elem_o = elems[k];
    end
  end
endmodule

// File: rtl/dotprod_mac.sv
module dotprod_mac #(
  parameter int unsigned IN_W  = dotprod_pkg::DP_IN_W,
  parameter int unsigned ACC_W = dotprod_pkg::DP_ACC_W
) (
  input  logic             clk_i,
  input  logic [IN_W-1:0]  a_i,
  input  logic [IN_W-1:0]  b_i,
  input  logic             restart_i,
  output logic [ACC_W-1:0] prod_o,
  output logic [ACC_W-1:0] acc_o
);
  logic signed [ACC_W-1:0] a_x, b_x, prod_w, addend_w;
  logic        [ACC_W-1:0] acc_q;

  assign a_x      = ACC_W'($signed(a_i));
  assign b_x      = ACC_W'($signed(b_i));
  assign prod_w   = a_x * b_x;
  // forced zero starts a new sum without a clear cycle
  assign addend_w = restart_i ? '0 : $signed(acc_q);

  always_ff @(posedge clk_i) begin
    acc_q <= prod_w + addend_w;
  end

  assign prod_o = prod_w;
  assign acc_o  = acc_q;
endmodule

// File: rtl/dotprod_serial.sv
module dotprod_serial #(
  parameter int unsigned N_ELEM = dotprod_pkg::DP_N_ELEM,
  parameter int unsigned IN_W   = dotprod_pkg::DP_IN_W,
  parameter int unsigned ACC_W  = dotprod_pkg::DP_ACC_W,
  localparam int unsigned CW    = (N_ELEM > 1) ? $clog2(N_ELEM) : 1,
  localparam int unsigned VW    = N_ELEM * IN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VW-1:0]    vec_a_i,
  input  logic [VW-1:0]    vec_b_i,
  output logic [ACC_W-1:0] dot_o,
  output logic             dot_valid_o
);
  logic [CW-1:0]    sel_w;
  logic             first_w;
  logic [IN_W-1:0]  elem_a_w, elem_b_w;
  logic [ACC_W-1:0] prod_w;

  dotprod_ctrl #(.N_ELEM(N_ELEM)) u_ctrl (
    .clk_i, .rst_ni, .sel_o(sel_w), .first_o(first_w), .done_o(dot_valid_o)
  );

  dotprod_elem_sel #(.N_ELEM(N_ELEM), .IN_W(IN_W)) u_sel_a (
    .vec_i(vec_a_i), .sel_i(sel_w), .elem_o(elem_a_w)
  );

  dotprod_elem_sel #(.N_ELEM(N_ELEM), .IN_W(IN_W)) u_sel_b (
    .vec_i(vec_b_i), .sel_i(sel_w), .elem_o(elem_b_w)
  );

  dotprod_mac #(.IN_W(IN_W), .ACC_W(ACC_W)) u_mac (
    .clk_i, .a_i(elem_a_w), .b_i(elem_b_w), .restart_i(first_w),
    .prod_o(prod_w), .acc_o(dot_o)
  );
endmodule

// File: rtl/dotprod_serial_chk.sv
module dotprod_serial_chk #(
  parameter int unsigned N_ELEM = 8,
  parameter int unsigned IN_W   = 8,
  parameter int unsigned ACC_W  = 16,
  localparam int unsigned CW    = (N_ELEM > 1) ? $clog2(N_ELEM) : 1,
  localparam int unsigned VW    = N_ELEM * IN_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [VW-1:0]    vec_a_i,
  input logic [VW-1:0]    vec_b_i,
  input logic [CW-1:0]    cnt_i,
  input logic [ACC_W-1:0] prod_i,
  input logic [ACC_W-1:0] acc_i,
  input logic             valid_i
);
  logic [CW-1:0] chk_cnt;
  logic          chk_wrapped;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_cnt     <= '0;
      chk_wrapped <= 1'b0;
    end else begin
      chk_cnt <= (chk_cnt == CW'(N_ELEM - 1)) ? '0 : chk_cnt + 1'b1;
      if (chk_cnt == CW'(N_ELEM - 1)) chk_wrapped <= 1'b1;
    end
  end

  p_inputs_stable_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != '0) |-> ($stable(vec_a_i) && $stable(vec_b_i)));

  p_valid_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  p_valid_due_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_cnt == '0 && chk_wrapped) |-> valid_i);

  p_no_early_valid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (chk_cnt == '0 && chk_wrapped));

  p_wrap_accum_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i != '0) |=> (acc_i == ACC_W'($past(acc_i) + $past(prod_i))));

  p_restart_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0) |=> (acc_i == $past(prod_i)));

  p_order_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i == chk_cnt);
endmodule

bind dotprod_serial dotprod_serial_chk #(
  .N_ELEM(N_ELEM), .IN_W(IN_W), .ACC_W(ACC_W)
) u_chk (
  .clk_i, .rst_ni, .vec_a_i, .vec_b_i,
  .cnt_i(sel_w), .prod_i(prod_w), .acc_i(dot_o), .valid_i(dot_valid_o)
);

// File: tb/sim_dotprod_serial.sv
`timescale 1ns/1ps
module sim_dotprod_serial;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] vec_a_i = '0, vec_b_i = '0;
  logic [15:0] dot_o;
  logic        dot_valid_o;

  int checks = 0;
  int failures = 0;

  always #4 clk_i = ~clk_i;

  dotprod_serial u0 (.clk_i, .rst_ni, .vec_a_i, .vec_b_i, .dot_o, .dot_valid_o);

  function automatic logic [15:0] ref_dot(logic [63:0] a, logic [63:0] b);
    int s = 0;
    for (int k = 0; k < 8; k++) s += int'($signed(a[k*8 +: 8])) * int'($signed(b[k*8 +: 8]));
    return s[15:0];
  endfunction

  task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // caller has loaded the vectors at a negedge where a pass starts
  task automatic run_pass(string req);
    logic [15:0] exp = ref_dot(vec_a_i, vec_b_i);
    for (int i = 0; i < 8; i++) begin
      @(posedge clk_i);
      @(negedge clk_i);
      if (i < 7) check(dot_valid_o == 1'b0, "R2/R3 no strobe inside pass", 16'(dot_valid_o), 16'd0);
    end
    check(dot_valid_o == 1'b1, "R2/R3 strobe at pass end", 16'(dot_valid_o), 16'd1);
    check(dot_o == exp, req, dot_o, exp);
  endtask

  function automatic logic [63:0] fill(logic [7:0] v);
    return {8{v}};
  endfunction

  initial begin
    logic [31:0] lfsr = 32'h1ACE_B00C;
    vec_a_i = 64'h0807_0605_0403_0201;
    vec_b_i = 64'h0101_0101_0101_0101;
    repeat (3) @(negedge clk_i);
    check(dot_valid_o == 1'b0, "R3 strobe low in reset", 16'(dot_valid_o), 16'd0);
    rst_ni = 1'b1;
    run_pass("R7 ascending elements, sum 36");

    vec_a_i = 64'h0807_0605_0403_0201;
    vec_b_i = 64'h0000_0000_0000_0001;
    run_pass("R7 element 0 only");
    vec_b_i = 64'h0100_0000_0000_0000;
    run_pass("R7 element 7 only");

    vec_a_i = fill(8'h80); vec_b_i = fill(8'h80);
    run_pass("R4 all -128 wraps to 0");
    vec_a_i = fill(8'h7F); vec_b_i = fill(8'h7F);
    run_pass("R4 all 127 wraps to F808");
    check(dot_o == 16'hF808, "R4 literal F808", dot_o, 16'hF808);
    vec_a_i = fill(8'h80); vec_b_i = fill(8'h7F);
    run_pass("R4 -128 by 127");

    // R5 back-to-back independent passes, R1 sweep of one scalar
    vec_b_i = 64'h7F80_03FD_11EF_01FF;
    for (int v = 0; v < 256; v++) begin
      vec_a_i = fill(8'(v));
      run_pass("R1/R5 scalar sweep");
    end

    for (int n = 0; n < 200; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      vec_a_i = {lfsr, ~lfsr ^ 32'h5A5A_0F0F};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      vec_b_i = {lfsr ^ 32'hC3C3_3C3C, lfsr};
      run_pass("R1 pseudo-random vectors");
    end

    // R6 reset mid-pass
    vec_a_i = fill(8'h05); vec_b_i = fill(8'h03);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b0;
    vec_a_i = fill(8'hF9); vec_b_i = fill(8'h0B);
    @(negedge clk_i);
    check(dot_valid_o == 1'b0, "R6 strobe low in mid-pass reset", 16'(dot_valid_o), 16'd0);
    rst_ni = 1'b1;
    run_pass("R6 sum after mid-pass reset");
    run_pass("R6 pass following restart");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule